// File: doc/BRIEF.md
# Core Debug Status Word with Prioritized State Code

This block gathers the condition signals that a processor core raises about itself and turns them into one 32-bit debug status word. The core can be in several conditions at once: stalled on the bus or running a built-in self test, parked in a wait or stop state, or halted in debug mode. A fixed priority reduces these to a single 2-bit state code, which occupies the top two bits of the word. When no condition is raised, the code reports that the core is executing.

The word also holds two flags. The first is a sticky flag that records that the most recent execution set was aborted. The second is a read-only flag that is captured when debug mode is entered and tells whether that entry happened inside a delay slot. Software or a debugger reads the word through a simple one-cycle read port.

The 2-bit state code is also carried into the test clock domain. There it forms the low bits of the value that a JTAG instruction register loads on capture. This keeps the core state visible to the debugger when the core clock has been stopped.

Top module: `dbgstat_top`

## Requirements
- R1: A synchronous active-high reset on `rst` sets the state code to 00, clears both flags and sets `rd_valid` and `rd_data` to zero. A synchronous active-high reset on `tck_rst` sets the low two bits of `ir_capture` to 00.
- R2: When `bus_wait` or `bist_mode` is high at a rising clock edge, the state code from that edge on is 10, whatever the other condition inputs are.
- R3: When `wait_stop` is high and neither `bus_wait` nor `bist_mode` is high at an edge, the code becomes 01, even when `debug_mode` is also high.
- R4: When only `debug_mode` is high, the code becomes 11. When no condition input is high, the code becomes 00, which means executing.
- R5: The word layout is: bits 31:30 hold the state code, bit 28 holds the abort flag and bit 24 holds the delay-slot flag. Every other bit, bit 29 included, reads as 0.
- R6: A high `set_aborted` at an edge sets the abort flag. The flag stays set until it is cleared. When `set_aborted` and `set_executed` are high in the same cycle, the flag is set.
- R7: A high `set_executed` at an edge clears the abort flag, provided `set_aborted` is low in that cycle.
- R8: At the edge where `debug_mode` is first seen high, the delay-slot flag takes the value of `in_delay_slot`. It then holds that value while `debug_mode` stays high, and clears at the first edge where `debug_mode` is low.
- R9: A high `rd_en` at an edge makes `rd_valid` high for the next cycle. In that cycle `rd_data` holds the word as it stood before that edge.
- R10: Once the state code has been stable for four rising edges of `tck`, the low two bits of `ir_capture` equal that code. The upper six bits always equal the upper six bits of `IR_FILL` (default 8'hA4, so 6'b101001). The capture value keeps being presented while `clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| bus_wait | input | 1 | Core is waiting for a bus transfer |
| bist_mode | input | 1 | Core is in a built-in self test mode |
| wait_stop | input | 1 | Core is in a wait or stop state |
| debug_mode | input | 1 | Core is halted in debug mode |
| in_delay_slot | input | 1 | Core is currently inside a delay slot |
| set_aborted | input | 1 | Pulse: the last execution set was aborted |
| set_executed | input | 1 | Pulse: a new execution set has executed |
| rd_en | input | 1 | Read request for the status word |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Status word returned by a read |
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, test clock domain |
| ir_capture | output | 8 | Instruction register capture value |

## Verification
Two events can land in the same core cycle: an abort pulse together with an execute pulse, and a read request together with a flag update. The bench raises `set_aborted` and `set_executed` together and then expects the abort flag to be set. It also raises `set_aborted` in the same cycle as `rd_en`. For that read, the returned word must still show the old flag, and the next read must show the new one. Every combination of the four condition inputs is swept. The expected code is derived arithmetically from the stated priority.

// File: rtl/dbgstat_pkg.sv
package dbgstat_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        CODE_RUN  = 2'b00,
        CODE_IDLE = 2'b01,
        CODE_BUS  = 2'b10,
        CODE_DBG  = 2'b11
    } state_code_e;

    typedef struct packed {
        logic bus;
        logic bist;
        logic idle;
        logic dbg;
    } core_cond_t;

    typedef struct packed {
        logic [1:0]  code;
        logic        rsv_a;
        logic        killed;
        logic [2:0]  rsv_b;
        logic        no_cof;
        logic [23:0] rsv_c;
    } status_word_t;

    localparam logic [WORD_W-1:0] RSV_MASK = 32'h2EFF_FFFF;

    function automatic state_code_e encode_state(input core_cond_t c);
        state_code_e r;
        if (c.bus || c.bist)  r = CODE_BUS;
        else if (c.idle)      r = CODE_IDLE;
        else if (c.dbg)       r = CODE_DBG;
        else                  r = CODE_RUN;
        return r;
    endfunction

    function automatic status_word_t pack_word(input state_code_e code,
                                               input logic killed,
                                               input logic no_cof);
        status_word_t w;
        w        = '0;
        w.code   = code;
        w.killed = killed;
        w.no_cof = no_cof;
        return w;
    endfunction

endpackage

// File: rtl/dbgstat_prio.sv
module dbgstat_prio
    import dbgstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  core_cond_t  cond,
    output state_code_e code_q
);

    always_ff @(posedge clk) begin
        if (rst) code_q <= CODE_RUN;
        else     code_q <= encode_state(cond);
    end

    AST_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
        (cond.bus || cond.bist) |=> (code_q == CODE_BUS)); // R2

    AST_IDLE_OVER_DBG: assert property (@(posedge clk) disable iff (rst)
        (!cond.bus && !cond.bist && cond.idle) |=> (code_q == CODE_IDLE)); // R3

    AST_DBG_ALONE: assert property (@(posedge clk) disable iff (rst)
        (!cond.bus && !cond.bist && !cond.idle && cond.dbg) |=> (code_q == CODE_DBG)); // R4

endmodule

// File: rtl/dbgstat_flags.sv
module dbgstat_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_aborted,
    input  logic set_executed,
    input  logic debug_mode,
    input  logic in_delay_slot,
    output logic killed_q,
    output logic no_cof_q
);

    logic dbg_seen_q;
    logic dbg_entry;

    assign dbg_entry = debug_mode && !dbg_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            killed_q   <= 1'b0;
            no_cof_q   <= 1'b0;
            dbg_seen_q <= 1'b0;
        end else begin
            dbg_seen_q <= debug_mode;
            if (set_aborted)       killed_q <= 1'b1;
            else if (set_executed) killed_q <= 1'b0;
            if (dbg_entry)         no_cof_q <= in_delay_slot;
            else if (!debug_mode)  no_cof_q <= 1'b0;
        end
    end

    AST_KILL_SET: assert property (@(posedge clk) disable iff (rst)
        set_aborted |=> killed_q); // R6

    AST_KILL_CLR: assert property (@(posedge clk) disable iff (rst)
        (set_executed && !set_aborted) |=> !killed_q); // R7

    AST_NOCOF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dbg_seen_q && debug_mode) |=> $stable(no_cof_q)); // R8

    AST_NOCOF_DROP: assert property (@(posedge clk) disable iff (rst)
        !debug_mode |=> !no_cof_q); // R8

endmodule

// File: rtl/dbgstat_tck_sync.sv
module dbgstat_tck_sync #(
    parameter int               SYNC_STAGES = 2,
    parameter int               IR_WIDTH    = 8,
    parameter logic [IR_WIDTH-1:0] IR_FILL  = 8'hA4
) (
    input  logic                tck,
    input  logic                tck_rst,
    input  logic [1:0]          code_async,
    output logic [IR_WIDTH-1:0] ir_capture
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [1:0] chain [SYNC_STAGES];
    logic [1:0] hold_q;
    logic [1:0] cap_code_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge tck) begin
                if (tck_rst) chain[0] <= 2'b00;
                else         chain[0] <= code_async;
            end
        end else begin : g_next
            always_ff @(posedge tck) begin
                if (tck_rst) chain[g] <= 2'b00;
                else         chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge tck) begin
        if (tck_rst) begin
            hold_q     <= 2'b00;
            cap_code_q <= 2'b00;
        end else begin
            hold_q <= chain[LAST];
            if (chain[LAST] == hold_q) cap_code_q <= hold_q;
        end
    end

    assign ir_capture = {IR_FILL[IR_WIDTH-1:2], cap_code_q};

    AST_CAP_FILTER: assert property (@(posedge tck) disable iff (tck_rst)
        (chain[LAST] != hold_q) |=> $stable(cap_code_q)); // R10

endmodule

// File: rtl/dbgstat_top.sv
module dbgstat_top
    import dbgstat_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter int                  IR_WIDTH    = 8,
    parameter logic [IR_WIDTH-1:0] IR_FILL     = 8'hA4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wait,
    input  logic                bist_mode,
    input  logic                wait_stop,
    input  logic                debug_mode,
    input  logic                in_delay_slot,
    input  logic                set_aborted,
    input  logic                set_executed,
    input  logic                rd_en,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                tck,
    input  logic                tck_rst,
    output logic [IR_WIDTH-1:0] ir_capture
);

    core_cond_t   cond;
    state_code_e  code_q;
    logic         killed_q;
    logic         no_cof_q;
    status_word_t word;

    assign cond = '{bus: bus_wait, bist: bist_mode, idle: wait_stop, dbg: debug_mode};

    dbgstat_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .cond   (cond),
        .code_q (code_q)
    );

    dbgstat_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .set_aborted   (set_aborted),
        .set_executed  (set_executed),
        .debug_mode    (debug_mode),
        .in_delay_slot (in_delay_slot),
        .killed_q      (killed_q),
        .no_cof_q      (no_cof_q)
    );

    dbgstat_tck_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .IR_WIDTH    (IR_WIDTH),
        .IR_FILL     (IR_FILL)
    ) u_tck (
        .tck        (tck),
        .tck_rst    (tck_rst),
        .code_async (code_q),
        .ir_capture (ir_capture)
    );

    assign word = pack_word(code_q, killed_q, no_cof_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= word;
        end
    end

    AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R9

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & RSV_MASK) == '0)); // R5

endmodule

// File: tb/sim_dbgstat_top.sv
`timescale 1ns/1ps
module sim_dbgstat_top;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        tck = 1'b0;
    logic        rst, tck_rst;
    logic        bus_wait, bist_mode, wait_stop, debug_mode, in_delay_slot;
    logic        set_aborted, set_executed, rd_en;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  ir_capture;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always begin
        #2.5;
        if (clk_run) clk = ~clk;
    end
    always #20 tck = ~tck;

    dbgstat_top u0 (
        .clk(clk), .rst(rst), .bus_wait(bus_wait), .bist_mode(bist_mode),
        .wait_stop(wait_stop), .debug_mode(debug_mode), .in_delay_slot(in_delay_slot),
        .set_aborted(set_aborted), .set_executed(set_executed), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .tck(tck), .tck_rst(tck_rst),
        .ir_capture(ir_capture)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input bit b, input bit t, input bit w, input bit d);
        return (b || t) ? 2'd2 : w ? 2'd1 : d ? 2'd3 : 2'd0;
    endfunction

    function automatic logic [31:0] exp_word(input logic [1:0] c, input bit k, input bit n);
        return (32'(c) << 30) | (32'(k) << 28) | (32'(n) << 24);
    endfunction

    task automatic read_word(output logic [31:0] w, output logic v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        w = rd_data;
        v = rd_valid;
    endtask

    task automatic set_cond(input bit b, input bit t, input bit w, input bit d);
        @(negedge clk);
        bus_wait = b; bist_mode = t; wait_stop = w; debug_mode = d;
    endtask

    task automatic pulse(input bit ab, input bit ex);
        @(negedge clk);
        set_aborted = ab; set_executed = ex;
        @(negedge clk);
        set_aborted = 1'b0; set_executed = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic        v;
        rst = 1'b1; tck_rst = 1'b1;
        {bus_wait, bist_mode, wait_stop, debug_mode, in_delay_slot} = '0;
        {set_aborted, set_executed, rd_en} = '0;
        repeat (3) @(posedge tck);
        @(negedge clk);
        // R1: reset state
        check(rd_valid == 1'b0 && rd_data == 32'h0, "R1", rd_data, 32'h0);
        check(ir_capture == 8'hA4, "R1", 32'(ir_capture), 32'hA4);
        rst = 1'b0; tck_rst = 1'b0;
        read_word(w, v);
        check(v && w == 32'h0, "R1", w, 32'h0);

        // R2 R3 R4: sweep all condition combinations
        for (int i = 0; i < 16; i++) begin
            logic [1:0] ec;
            string tag;
            ec = exp_code(i[3], i[2], i[1], i[0]);
            tag = (ec == 2'd2) ? "R2" : (ec == 2'd1) ? "R3" : "R4";
            set_cond(i[3], i[2], i[1], i[0]);
            read_word(w, v);
            check(v && w == exp_word(ec, 0, 0), tag, w, exp_word(ec, 0, 0));
        end

        // R5: reserved bits read zero with both flags set
        set_cond(0, 0, 0, 0);
        in_delay_slot = 1'b1;
        set_cond(0, 0, 0, 1);
        pulse(1, 0);
        read_word(w, v);
        check(w == exp_word(2'd3, 1, 1), "R5", w, exp_word(2'd3, 1, 1));
        check((w & 32'h2EFF_FFFF) == 0, "R5", w & 32'h2EFF_FFFF, 0);

        // R8: flag held while in debug even if delay slot input changes
        in_delay_slot = 1'b0;
        read_word(w, v);
        check(w[24] == 1'b1, "R8", 32'(w[24]), 1);
        set_cond(0, 0, 0, 0);
        read_word(w, v);
        check(w[24] == 1'b0, "R8", 32'(w[24]), 0);
        set_cond(0, 0, 0, 1);
        read_word(w, v);
        check(w[24] == 1'b0, "R8", 32'(w[24]), 0);
        set_cond(0, 0, 0, 0);

        // R7: execute clears the abort flag
        pulse(0, 1);
        read_word(w, v);
        check(w[28] == 1'b0, "R7", 32'(w[28]), 0);
        // R6: abort and execute together leave the flag set
        pulse(1, 1);
        read_word(w, v);
        check(w[28] == 1'b1, "R6", 32'(w[28]), 1);
        pulse(0, 0);
        read_word(w, v);
        check(w[28] == 1'b1, "R6", 32'(w[28]), 1);
        pulse(0, 1);

        // R9: a read in the same cycle as an abort sees the old word
        @(negedge clk);
        set_aborted = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        set_aborted = 1'b0; rd_en = 1'b0;
        check(rd_valid && rd_data[28] == 1'b0, "R9", rd_data, 32'h0);
        @(negedge clk);
        check(rd_valid == 1'b0, "R9", 32'(rd_valid), 0);
        read_word(w, v);
        check(v && w[28] == 1'b1, "R9", w, exp_word(0, 1, 0));
        pulse(0, 1);

        // R10: JTAG capture follows the code
        for (int i = 0; i < 4; i++) begin
            logic [1:0] ec;
            ec = exp_code(i == 1, 0, i == 2, i == 3);
            set_cond(i == 1, 0, i == 2, i == 3);
            repeat (6) @(posedge tck);
            @(negedge tck);
            check(ir_capture == {6'b101001, ec}, "R10", 32'(ir_capture), 32'({6'b101001, ec}));
        end
        // R10: with the core clock stopped the capture still shows the last code
        set_cond(0, 1, 0, 0);
        repeat (6) @(posedge tck);
        @(negedge clk);
        clk_run = 1'b0;
        bist_mode = 1'b0;
        repeat (8) @(posedge tck);
        @(negedge tck);
        check(ir_capture == 8'hA6, "R10", 32'(ir_capture), 32'hA6);
        clk_run = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule